// File: doc/BRIEF.md
# Serial Link Self-Test Payload Checker

This block is the receive-side checker of an at-speed self-test for a high-speed serial link. While a level-sensitive test enable input is held high, the checker waits for the receiver to report lock. It then compares every received 35-bit payload word against the expected all-zero test pattern. The length of the enable pulse sets how long the test runs.

A single status output serves two purposes. While checking, it sits high and drops low for the low half of one clock period after each errored payload. External logic can count those pulses to measure the payload error rate. When the enable falls, the output holds the final verdict until a new test starts, a reset is applied or the power-down input is asserted. The verdict is high for a clean run and low otherwise.

A saturating 8-bit error counter and a live lock status bit can be read through a small combinational register read port. All logic runs in the recovered pixel-clock domain with a synchronous active-high reset.

Top module: `lbist_rx_checker`

## Requirements
- R1: After reset or power-down the status output is low. A rising edge of the enable, sampled at a clock edge, starts a test. The status output stays low until the checker has seen lock at a clock edge in which the enable is high. From the following edge it is high while checking.
- R2: While checking, with the lock input and the valid strobe high at an edge, a payload is errored exactly when any of its 35 bits is 1. An all-zero payload is not an error.
- R3: A payload with any number of bit errors from 1 to 35 counts as one errored payload and advances the error counter by exactly one.
- R4: In the clock cycle that follows the edge at which an errored payload was sampled, the status output is high while the clock is high and low while the clock is low. Outside such cycles it stays high during checking.
- R5: The first edge that samples the enable low ends the test. From that edge on, the status output is high if lock was reached and no failure was recorded, and low otherwise.
- R6: The verdict holds unchanged until the next test start, a reset, or a power-down assertion. Both reset and power-down drive the status output low.
- R7: Register address 0 returns the error counter. It is 8 bits wide, saturates at 255, and is cleared to 0 by the edge that starts a test.
- R8: Register address 1 returns the lock status in bit 0, with bits 7..1 reading as zero. The bit equals the lock input as sampled at the most recent clock edge.
- R9: Payloads are not checked when they arrive before lock, while lock is low during the test, or with the valid strobe low. A loss of lock during checking records a failure in the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Synchronous power-down; clears the test and held verdict |
| test_en | input | 1 | Test enable level; high for the duration of the test |
| lock | input | 1 | Receiver lock indication |
| pay_valid | input | 1 | Payload valid strobe |
| pay_data | input | 35 | Received payload word |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| status_o | output | 1 | Live error pulses during the test, held verdict after it |

## Verification
The comparison is driven with all-zero words, a single set bit, all 35 bits set, and a long run of errored words. Together these separate a correct any-bit test from a per-bit count, and show that the counter saturates. Nonzero words are also presented with the valid strobe low, before lock and during a lock dropout. Each of these must leave both the counter and the verdict untouched, while the dropout itself must still fail the test. The status output is sampled in both clock phases, so a pulse that lasts the whole cycle or lands in the wrong phase is distinguished from the intended low-half pulse.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int unsigned PAY_W_DEF  = 35;
    localparam int unsigned CNT_W_DEF  = 8;
    localparam int unsigned ADDR_W_DEF = 2;

    localparam int unsigned REG_ERRCNT = 0;
    localparam int unsigned REG_LOCK   = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CHECK = 2'd2,
        ST_DONE  = 2'd3
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
    } en_evt_t;

    typedef struct packed {
        logic seen_lock;
        logic fail;
    } verdict_t;

    function automatic logic verdict_pass(verdict_t v);
        return v.seen_lock & ~v.fail;
    endfunction

endpackage

// File: rtl/lbist_en_sampler.sv
module lbist_en_sampler
    import lbist_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pwr_down,
    input  logic    test_en,
    output logic    en_q,
    output en_evt_t evt
);

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            en_q <= 1'b0;
        end else begin
            en_q <= test_en;
        end
    end

    always_comb begin
        evt.start = test_en & ~en_q;
        evt.stop  = ~test_en & en_q;
    end

endmodule

// File: rtl/lbist_payload_cmp.sv
module lbist_payload_cmp #(
    parameter int unsigned PAY_W = 35
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_down,
    input  logic             check_win,
    input  logic             pay_valid,
    input  logic [PAY_W-1:0] pay_data,
    output logic             err_now,
    output logic             err_q
);

    // Expected pattern is all zeros: any set bit marks the word as errored.
    assign err_now = check_win & pay_valid & (|pay_data);

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_now;
        end
    end

endmodule

// File: rtl/lbist_sat_counter.sv
module lbist_sat_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwr_down,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || pwr_down || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
    import lbist_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_down,
    input  en_evt_t  evt,
    input  logic     test_en,
    input  logic     lock,
    input  logic     err_now,
    output phase_t   phase,
    output verdict_t verdict
);

    phase_t   phase_n;
    verdict_t verdict_n;

    always_comb begin
        phase_n   = phase;
        verdict_n = verdict;
        if (evt.start) begin
            phase_n   = ST_ARMED;
            verdict_n = '0;
        end else begin
            unique case (phase)
                ST_ARMED: begin
                    if (!test_en) begin
                        phase_n = ST_DONE;
                    end else if (lock) begin
                        phase_n             = ST_CHECK;
                        verdict_n.seen_lock = 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (!test_en) begin
                        phase_n = ST_DONE;
                    end else if (!lock) begin
                        phase_n        = ST_ARMED;
                        verdict_n.fail = 1'b1;
                    end else if (err_now) begin
                        verdict_n.fail = 1'b1;
                    end
                end
                default: begin
                    phase_n = phase;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            phase   <= ST_IDLE;
            verdict <= '0;
        end else begin
            phase   <= phase_n;
            verdict <= verdict_n;
        end
    end

endmodule

// File: rtl/lbist_rx_checker.sv
module lbist_rx_checker
    import lbist_pkg::*;
#(
    parameter int unsigned PAY_W  = PAY_W_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_down,
    input  logic              test_en,
    input  logic              lock,
    input  logic              pay_valid,
    input  logic [PAY_W-1:0]  pay_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              status_o
);

    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(REG_ERRCNT);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(REG_LOCK);

    logic             en_q;
    en_evt_t          evt;
    phase_t           phase_q;
    verdict_t         verdict_q;
    logic             check_win;
    logic             err_now;
    logic             err_q;
    logic [CNT_W-1:0] cnt_q;
    logic             lock_q;

    lbist_en_sampler u_en (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .test_en  (test_en),
        .en_q     (en_q),
        .evt      (evt)
    );

    assign check_win = (phase_q == ST_CHECK) & test_en & lock;

    lbist_payload_cmp #(.PAY_W(PAY_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .pwr_down  (pwr_down),
        .check_win (check_win),
        .pay_valid (pay_valid),
        .pay_data  (pay_data),
        .err_now   (err_now),
        .err_q     (err_q)
    );

    lbist_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .evt      (evt),
        .test_en  (test_en),
        .lock     (lock),
        .err_now  (err_now),
        .phase    (phase_q),
        .verdict  (verdict_q)
    );

    lbist_sat_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .clr      (evt.start),
        .inc      (err_now),
        .cnt      (cnt_q)
    );

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CNT) begin
            rd_data = cnt_q;
        end else if (rd_addr == A_LOCK) begin
            rd_data[0] = lock_q;
        end
    end

    // Live phase: error flag registered at the rising edge, gated by the low clock half.
    always_comb begin
        unique case (phase_q)
            ST_CHECK: status_o = ~(err_q & ~clk);
            ST_DONE:  status_o = verdict_pass(verdict_q);
            default:  status_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lbist_rx_checker_chk.sv
module lbist_rx_checker_chk
    import lbist_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pwr_down,
    input logic             test_en,
    input logic             lock,
    input logic             status_o,
    input phase_t           phase,
    input logic             err_q,
    input logic [CNT_W-1:0] cnt,
    input logic             fail,
    input logic             en_q
);

    logic start_c;
    assign start_c = test_en & ~en_q;

    p_start_clear_r7: assert property (@(posedge clk) disable iff (rst || pwr_down)
        start_c |=> (cnt == '0));

    p_sat_hold_r7: assert property (@(posedge clk) disable iff (rst || pwr_down)
        ((cnt == '1) && !start_c) |=> (cnt == '1));

    p_single_step_r3: assert property (@(posedge clk) disable iff (rst || pwr_down)
        !start_c |=> ((cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1))));

    p_unlocked_quiet_r9: assert property (@(posedge clk) disable iff (rst || pwr_down)
        !lock |=> !err_q);

    p_lockloss_fail_r9: assert property (@(posedge clk) disable iff (rst || pwr_down)
        ((phase == ST_CHECK) && test_en && !lock) |=> fail);

    p_verdict_hold_r6: assert property (@(posedge clk) disable iff (rst || pwr_down)
        ((phase == ST_DONE) && !test_en) |=> ((phase == ST_DONE) && $stable(fail)));

    p_armed_low_r1: assert property (@(posedge clk) disable iff (rst || pwr_down)
        (phase == ST_ARMED) |-> !status_o);

endmodule

bind lbist_rx_checker lbist_rx_checker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_down (pwr_down),
    .test_en  (test_en),
    .lock     (lock),
    .status_o (status_o),
    .phase    (phase_q),
    .err_q    (err_q),
    .cnt      (cnt_q),
    .fail     (verdict_q.fail),
    .en_q     (en_q)
);

// File: tb/lbist_rx_checker_bench.sv
`timescale 1ns/1ps
module lbist_rx_checker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_down = 1'b0;
    logic        test_en = 1'b0;
    logic        lock = 1'b0;
    logic        pay_valid = 1'b0;
    logic [34:0] pay_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [7:0]  rd_data;
    logic        status_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lbist_rx_checker u_lbist_rx_checker (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .test_en  (test_en),
        .lock     (lock),
        .pay_valid(pay_valid),
        .pay_data (pay_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .status_o (status_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance to 1 ns after the next rising edge (clock high phase).
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic read_reg(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // Sample status in the high phase now and in the low phase 4 ns later.
    task automatic phases(output int hi, output int lo);
        hi = int'(status_o);
        #4;
        lo = int'(status_o);
    endtask

    task automatic begin_test(input logic lk);
        test_en = 1'b1;
        lock = lk;
        step();
        step();
    endtask

    task automatic end_test();
        test_en = 1'b0;
        pay_valid = 1'b0;
        step();
    endtask

    task automatic send(input logic [34:0] d, input logic v);
        pay_valid = v;
        pay_data = d;
        step();
        pay_valid = 1'b0;
        pay_data = '0;
    endtask

    task automatic t_reset();
        int v;
        chk("R1", "status after reset", int'(status_o), 0);
        read_reg(2'd0, v);
        chk("R7", "counter after reset", v, 0);
        read_reg(2'd1, v);
        chk("R8", "lock reg after reset", v, 0);
    endtask

    task automatic t_clean();
        int hi, lo, v;
        begin_test(1'b1);
        phases(hi, lo);
        chk("R1", "status high once locked (hi)", hi, 1);
        chk("R1", "status high once locked (lo)", lo, 1);
        for (int i = 0; i < 4; i++) send('0, 1'b1);
        phases(hi, lo);
        chk("R2", "zero payload no pulse", lo, 1);
        read_reg(2'd0, v);
        chk("R2", "zero payloads count", v, 0);
        end_test();
        chk("R5", "clean verdict", int'(status_o), 1);
        repeat (5) step();
        chk("R6", "clean verdict held", int'(status_o), 1);
    endtask

    task automatic t_single_bit();
        int hi, lo, v;
        begin_test(1'b1);
        send(35'd1 << 17, 1'b1);
        phases(hi, lo);
        chk("R4", "pulse cycle clock-high half", hi, 1);
        chk("R4", "pulse cycle clock-low half", lo, 0);
        step();
        phases(hi, lo);
        chk("R4", "no pulse next cycle", lo, 1);
        read_reg(2'd0, v);
        chk("R2", "single set bit counted", v, 1);
        end_test();
        chk("R5", "errored verdict low", int'(status_o), 0);
        repeat (6) step();
        chk("R6", "errored verdict held", int'(status_o), 0);
    endtask

    task automatic t_all_bits();
        int hi, lo, v;
        begin_test(1'b1);
        send('1, 1'b1);
        phases(hi, lo);
        chk("R3", "35-bit error one pulse", lo, 0);
        read_reg(2'd0, v);
        chk("R3", "35 bit errors count once", v, 1);
        send(35'h4_0000_0003, 1'b1);
        read_reg(2'd0, v);
        chk("R3", "three bit errors count once", v, 2);
        end_test();
    endtask

    task automatic t_unchecked();
        int hi, lo, v;
        begin_test(1'b0);
        chk("R1", "status low before lock", int'(status_o), 0);
        send('1, 1'b1);
        read_reg(2'd0, v);
        chk("R9", "pre-lock payload ignored", v, 0);
        lock = 1'b1;
        step();
        step();
        send('1, 1'b0);
        phases(hi, lo);
        chk("R9", "valid low no pulse", lo, 1);
        read_reg(2'd0, v);
        chk("R9", "valid low not counted", v, 0);
        end_test();
        chk("R9", "verdict pass after ignored payloads", int'(status_o), 1);
    endtask

    task automatic t_lock_loss();
        int v;
        begin_test(1'b1);
        lock = 1'b0;
        step();
        chk("R9", "status low on lock loss", int'(status_o), 0);
        send('1, 1'b1);
        read_reg(2'd0, v);
        chk("R9", "unlocked payload ignored", v, 0);
        lock = 1'b1;
        step();
        step();
        chk("R1", "status high after relock", int'(status_o), 1);
        end_test();
        chk("R9", "lock loss fails verdict", int'(status_o), 0);
    endtask

    task automatic t_never_locked();
        begin_test(1'b0);
        end_test();
        chk("R5", "never locked verdict low", int'(status_o), 0);
    endtask

    task automatic t_saturate();
        int v;
        begin_test(1'b1);
        pay_valid = 1'b1;
        pay_data = 35'd5;
        repeat (300) step();
        pay_valid = 1'b0;
        read_reg(2'd0, v);
        chk("R7", "counter saturates", v, 255);
        end_test();
        read_reg(2'd0, v);
        chk("R7", "counter held after test", v, 255);
        test_en = 1'b1;
        step();
        read_reg(2'd0, v);
        chk("R7", "counter cleared at start", v, 0);
        chk("R6", "new test clears held verdict", int'(status_o), 0);
        step();
        end_test();
        chk("R5", "fresh test passes", int'(status_o), 1);
    endtask

    task automatic t_power_down();
        pwr_down = 1'b1;
        step();
        pwr_down = 1'b0;
        chk("R6", "power-down clears verdict", int'(status_o), 0);
        step();
        chk("R6", "stays low after power-down", int'(status_o), 0);
    endtask

    task automatic t_lock_reg();
        int v;
        lock = 1'b1;
        step();
        read_reg(2'd1, v);
        chk("R8", "lock reg high", v, 1);
        lock = 1'b0;
        read_reg(2'd1, v);
        chk("R8", "lock reg before edge", v, 1);
        step();
        read_reg(2'd1, v);
        chk("R8", "lock reg low", v, 0);
    endtask

    task automatic t_reset_clear();
        begin_test(1'b1);
        end_test();
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R6", "reset clears pass verdict", int'(status_o), 0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_clean();
        t_single_bit();
        t_all_bits();
        t_unchecked();
        t_lock_loss();
        t_never_locked();
        t_saturate();
        t_power_down();
        t_lock_reg();
        t_reset_clear();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule